// File: doc/BRIEF.md
# Level-Interrupt GPIO Bank

This block is a bank of general-purpose I/O lines behind a word-addressed register bus. Software writes the values the lines drive and chooses, line by line, whether each line drives at all. It reads back the synchronized levels of the lines. Each line also feeds a level-sensitive interrupt source. The source compares the synchronized level against a per-line polarity choice and records a hit in a sticky status register. Software clears a status bit by writing a 1 to it. An enable mask selects which status bits reach the single interrupt output.

Status is level-latched. If software clears a bit while its line still shows the active level, the bit sets again on the next clock. For that reason the line's source has to be quieted before the bit is acknowledged. The bank also holds one 32-bit scratch word for pin-multiplexing settings. The bank only stores that word and gives it no meaning of its own.

Top module: `lvl_gpio_bank`

## Requirements
- R1: After a synchronous reset, every register reads 0, pin_out and pin_oe are all 0, and irq is 0.
- R2: The word at offset 0x00 holds the drive values and the word at 0x04 holds the drive enables. Bit n belongs to line n. pin_out[n] and pin_oe[n] follow those bits from the clock edge that writes them, and they hold while no write reaches them.
- R3: The word at 0x08 returns the line levels after a two-flop synchronizer, with bit n for line n. Writes to it have no effect.
- R4: Polarity for line n is bit 4*(n mod 8) of the word at 0x10 for lines 0 to 7, and of the word at 0x18 for lines 8 and above. A 0 in that bit means a high level is active, and a 1 means a low level is active. All other bits of both words read 0.
- R5: A status bit in the word at 0x0C becomes 1 one clock after the synchronized line shows its active level. It stays 1 after the level goes away, until it is cleared.
- R6: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged. A cleared bit whose line is still at its active level reads 1 again from the next clock.
- R7: The word at 0x14 is the interrupt enable mask, with 1 meaning unmasked. irq is registered. It is 1 exactly one clock after (status AND enable) is nonzero, and 0 otherwise.
- R8: The word at 0x1C is a full 32-bit read/write register.
- R9: Bits 12 to 31 of the per-line words read 0 and ignore writes. Offsets from 0x20 to 0x3C read 0, and writes to them change nothing.
- R10: bus_rdata is registered. It presents the addressed word on the clock edge that samples bus_rd high and holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the accessed word (bits 1:0 ignored) |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 12 | Asynchronous line levels |
| pin_out | output | 12 | Drive values |
| pin_oe | output | 12 | Drive enables, 1 means driving |
| irq | output | 1 | Combined level interrupt, registered |

## Verification
The bench builds the bank with its defaults: 12 lines and a 6-bit byte offset. With 12 lines, lines 8 to 11 fall into the second polarity word, so the split between the two polarity words is exercised. Bits 12 to 31 of the per-line words stay unused and can be checked for reading 0. The 6-bit offset leaves a window of eight undefined words above 0x1C, which lets the bench prove that reads there return 0 and writes there change nothing.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int REG_COUNT   = 8;
  localparam int POL_STRIDE  = 4;
  localparam int POL_PER_REG = 8;

  typedef enum logic [2:0] {
    W_DOUT   = 3'd0,
    W_OE     = 3'd1,
    W_IN     = 3'd2,
    W_STAT   = 3'd3,
    W_POL_LO = 3'd4,
    W_EN     = 3'd5,
    W_POL_HI = 3'd6,
    W_MUX    = 3'd7
  } word_e;
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_lvl_irqunit.sv
module gpio_lvl_irqunit #(
  parameter int NPINS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] level,
  input  logic [NPINS-1:0] active_low,
  input  logic [NPINS-1:0] enable,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] status,
  output logic             irq
);
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] status_nxt;

  always_comb begin
    hit        = level ^ active_low;
    status_nxt = (status | hit) & ~clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nxt;
      irq    <= |(status & enable);
    end
  end

  // R5
  sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
    (status != '0) |=> ((($past(status) & ~$past(clr)) & ~status) == '0));

  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr != '0) |=> ((status & $past(clr)) == '0));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & enable) != '0) |=> irq);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & enable) == '0) |=> !irq);
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
  import gpio_lvl_pkg::*;
#(
  parameter int NPINS  = 12,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPINS-1:0]  in_sync,
  input  logic [NPINS-1:0]  status,
  output logic [NPINS-1:0]  dout,
  output logic [NPINS-1:0]  oe,
  output logic [NPINS-1:0]  en,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  clr
);
  localparam int IDX_W = ADDR_W - 2;

  function automatic logic [DATA_W-1:0] pol_field_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < POL_PER_REG; i++) m[POL_STRIDE*i] = 1'b1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] POL_MASK = pol_field_mask();

  logic [IDX_W-1:0]  idx;
  logic              in_map;
  word_e             word;
  logic              wr_hit;
  logic [DATA_W-1:0] mux_q;
  logic [NPINS-1:0]  pol_nxt;
  logic [DATA_W-1:0] pol_lo_rd, pol_hi_rd;

  assign idx    = addr[ADDR_W-1:2];
  assign in_map = (idx[IDX_W-1:3] == '0);
  assign word   = word_e'(idx[2:0]);
  assign wr_hit = wr && in_map;
  assign clr    = (wr_hit && word == W_STAT) ? wdata[NPINS-1:0] : '0;

  always_comb begin
    pol_nxt   = pol;
    pol_lo_rd = '0;
    pol_hi_rd = '0;
    for (int k = 0; k < NPINS; k++) begin
      if ((k / POL_PER_REG) == 0) begin
        pol_lo_rd[POL_STRIDE*(k % POL_PER_REG)] = pol[k];
        if (wr_hit && word == W_POL_LO) pol_nxt[k] = wdata[POL_STRIDE*(k % POL_PER_REG)];
      end else begin
        pol_hi_rd[POL_STRIDE*(k % POL_PER_REG)] = pol[k];
        if (wr_hit && word == W_POL_HI) pol_nxt[k] = wdata[POL_STRIDE*(k % POL_PER_REG)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      oe    <= '0;
      en    <= '0;
      pol   <= '0;
      mux_q <= '0;
    end else begin
      pol <= pol_nxt;
      if (wr_hit) begin
        case (word)
          W_DOUT:  dout  <= wdata[NPINS-1:0];
          W_OE:    oe    <= wdata[NPINS-1:0];
          W_EN:    en    <= wdata[NPINS-1:0];
          W_MUX:   mux_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (!in_map) begin
        rdata <= '0;
      end else begin
        case (word)
          W_DOUT:   rdata <= DATA_W'(dout);
          W_OE:     rdata <= DATA_W'(oe);
          W_IN:     rdata <= DATA_W'(in_sync);
          W_STAT:   rdata <= DATA_W'(status);
          W_POL_LO: rdata <= pol_lo_rd;
          W_EN:     rdata <= DATA_W'(en);
          W_POL_HI: rdata <= pol_hi_rd;
          W_MUX:    rdata <= mux_q;
          default:  rdata <= '0;
        endcase
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == '0 && oe == '0 && en == '0 && pol == '0));

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_hit && word == W_DOUT) |=> $stable(dout));

  // R4
  pol_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && in_map && (word == W_POL_LO || word == W_POL_HI)) |=> ((rdata & ~POL_MASK) == '0));

  // R9
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !in_map) |=> (rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/lvl_gpio_bank.sv
module lvl_gpio_bank #(
  parameter int NPINS       = 12,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] in_sync;
  logic [NPINS-1:0] status;
  logic [NPINS-1:0] en;
  logic [NPINS-1:0] pol;
  logic [NPINS-1:0] clr;

  gpio_lvl_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  gpio_lvl_regs #(
    .NPINS  (NPINS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .in_sync (in_sync),
    .status  (status),
    .dout    (pin_out),
    .oe      (pin_oe),
    .en      (en),
    .pol     (pol),
    .clr     (clr)
  );

  gpio_lvl_irqunit #(
    .NPINS (NPINS)
  ) u_irq (
    .clk        (clk),
    .rst        (rst),
    .level      (in_sync),
    .active_low (pol),
    .enable     (en),
    .clr        (clr),
    .status     (status),
    .irq        (irq)
  );
endmodule

// File: tb/lvl_gpio_bank_tb.sv
module lvl_gpio_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_out;
  logic [11:0] pin_oe;
  logic        irq;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;

  lvl_gpio_bank u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  typedef struct packed {
    logic        is_wr;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] val;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 4'd2, 8'h00, 32'hFFFF_FFFF},  // R2 / R9
    '{1'b0, 4'd9, 8'h00, 32'h0000_0FFF},
    '{1'b1, 4'd2, 8'h04, 32'h0000_0A5A},  // R2
    '{1'b0, 4'd2, 8'h04, 32'h0000_0A5A},
    '{1'b1, 4'd8, 8'h1C, 32'hDEAD_BEEF},  // R8
    '{1'b0, 4'd8, 8'h1C, 32'hDEAD_BEEF},
    '{1'b1, 4'd4, 8'h10, 32'hFFFF_FFFF},  // R4
    '{1'b0, 4'd4, 8'h10, 32'h1111_1111},
    '{1'b1, 4'd4, 8'h18, 32'hFFFF_FFFF},  // R4
    '{1'b0, 4'd4, 8'h18, 32'h0000_1111},
    '{1'b1, 4'd7, 8'h14, 32'hFFFF_F0F0},  // R7 / R9
    '{1'b0, 4'd7, 8'h14, 32'h0000_00F0},
    '{1'b1, 4'd9, 8'h20, 32'h1234_5678},  // R9
    '{1'b0, 4'd9, 8'h20, 32'h0000_0000},
    '{1'b1, 4'd9, 8'h3C, 32'hFFFF_FFFF},  // R9
    '{1'b0, 4'd8, 8'h1C, 32'hDEAD_BEEF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a[5:0];
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a[5:0];
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d        = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    check("R1 pin_out", 32'(pin_out), 32'h0);
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    for (int a = 0; a < 8; a++) begin
      bus_read(8'(a * 4), rv);
      check("R1 register", rv, 32'h0);
    end

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].is_wr) begin
        bus_write(VEC[i].addr, VEC[i].val);
      end else begin
        bus_read(VEC[i].addr, rv);
        n_tests++;
        if (rv !== VEC[i].val) begin
          n_fail++;
          $display("FAIL R%0d: vector %0d actual %h expected %h", VEC[i].req, i, rv, VEC[i].val);
        end
      end
    end

    // R2: pins follow the registers
    check("R2 pin_out", 32'(pin_out), 32'h0000_0FFF);
    check("R2 pin_oe", 32'(pin_oe), 32'h0000_0A5A);
    // R10: rdata holds while no read
    idle(3);
    check("R10 rdata hold", bus_rdata, 32'hDEAD_BEEF);

    // quiet the interrupt unit
    bus_write(8'h10, 32'h0);
    bus_write(8'h18, 32'h0);
    bus_write(8'h14, 32'h0);
    idle(3);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    idle(2);
    bus_read(8'h0C, rv);
    check("R6 clear all", rv, 32'h0);
    check("R7 irq low", 32'(irq), 32'h0);

    // R3 / R5: line 3 high, active-high
    pin_in[3] = 1'b1;
    idle(4);
    bus_read(8'h08, rv);
    check("R3 input level", rv, 32'h0000_0008);
    bus_read(8'h0C, rv);
    check("R5 status set", rv, 32'h0000_0008);
    check("R7 masked irq", 32'(irq), 32'h0);
    bus_write(8'h14, 32'h0000_0008);
    idle(2);
    check("R7 unmasked irq", 32'(irq), 32'h1);

    // R5: sticky after level drops
    pin_in[3] = 1'b0;
    idle(4);
    bus_read(8'h0C, rv);
    check("R5 sticky", rv, 32'h0000_0008);
    check("R7 irq held", 32'(irq), 32'h1);

    // R6: clear with source gone
    bus_write(8'h0C, 32'h0000_0008);
    idle(3);
    bus_read(8'h0C, rv);
    check("R6 cleared", rv, 32'h0);
    check("R7 irq dropped", 32'(irq), 32'h0);

    // R6: clear while line 9 still active sets again
    pin_in[9] = 1'b1;
    idle(4);
    bus_write(8'h0C, 32'h0000_0200);
    idle(3);
    bus_read(8'h0C, rv);
    check("R6 re-set", rv, 32'h0000_0200);
    bus_write(8'h0C, 32'h0000_0000);
    idle(1);
    bus_read(8'h0C, rv);
    check("R6 zero write keeps", rv, 32'h0000_0200);

    // R4: line 10 active-low through the upper polarity word, bit 8
    pin_in[9] = 1'b0;
    idle(4);
    bus_write(8'h0C, 32'h0000_0FFF);
    idle(2);
    bus_write(8'h18, 32'h0000_0100);
    idle(3);
    bus_read(8'h0C, rv);
    check("R4 active-low line 10", rv, 32'h0000_0400);
    // R4: line 2 active-low through the lower polarity word, bit 8
    bus_write(8'h18, 32'h0);
    bus_write(8'h0C, 32'h0000_0FFF);
    bus_write(8'h10, 32'h0000_0100);
    idle(3);
    bus_read(8'h0C, rv);
    check("R4 active-low line 2", rv, 32'h0000_0004);

    // R3: writes to the input word are ignored
    pin_in[0] = 1'b1;
    idle(4);
    bus_write(8'h08, 32'h0);
    bus_read(8'h08, rv);
    check("R3 write ignored", rv, 32'h0000_0001);

    // R9: writes to undefined offsets left mux word intact
    bus_read(8'h1C, rv);
    check("R9 no alias", rv, 32'hDEAD_BEEF);

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    pin_in = '0;
    idle(1);
    check("R1 pin_oe after reset", 32'(pin_oe), 32'h0);
    check("R1 pin_out after reset", 32'(pin_out), 32'h0);
    bus_read(8'h1C, rv);
    check("R1 mux after reset", rv, 32'h0);
    bus_read(8'h14, rv);
    check("R1 enable after reset", rv, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule